// File: doc/BRIEF.md
# Byte-Bus 16-bit Timer with Capture and Dual Compare

This block is a 16-bit timer peripheral that sits on a byte-wide CPU register bus. It contains one counter, two compare channels and one capture register. The counter counts up while enabled and wraps back to zero after its ceiling. The ceiling is either all ones or the value held in the capture register. Each compare channel flags a match and can toggle its own output pin. The capture register takes a snapshot of the counter on a rising edge of one of two selectable inputs. Both inputs pass through a synchronizer first.

Every 16-bit register is reached through two byte addresses. One shared 8-bit holding latch turns these two byte accesses into a single 16-bit transfer, so the CPU never sees or creates a torn value. Event flags can be cleared by software. They reach the single interrupt line only through a mask and a global enable input. The register bus is a plain strobe interface with no back-pressure: a write or read takes effect on the clock edge where its strobe is high, and read data is valid in the same cycle as the strobe.

Address map (4-bit address):
- 0: control.
- 1: mask.
- 2: flags.
- Wide registers, low byte at the even address and high byte at the odd one:
  - counter: 4 and 5
  - compare A: 6 and 7
  - compare B: 8 and 9
  - capture: 10 and 11

Control bits:
- bit 0: run.
- bit 1: ceiling taken from the capture register.
- bit 2: capture source is the alternate input.
- bit 3: toggle enable for output A.
- bit 4: toggle enable for output B.

Mask and flag bits:
- bit 7: overflow.
- bit 6: compare A.
- bit 5: compare B.
- bit 3: capture.

Top module: `timer16_atomic`

## Requirements
- R1: A write to the odd (high) address of a wide register loads only the shared latch. The register keeps its old value until the matching even-address write.
- R2: A write to the even (low) address of a wide register stores {latch, data} into all 16 bits on that one clock edge.
- R3: A read of an even address returns the low byte and, on that edge, copies the register's high byte into the latch. A later odd-address read returns the latch even if the register changed in between.
- R4: The latch is shared by all four wide registers. A high-byte write to one register, followed by a high-byte write to another, leaves the second byte as the one committed by the next low-byte write.
- R5: With control bit 0 set, the counter advances by one per clock. With the bit clear, the counter holds. On reaching the ceiling it wraps to 0 and sets flag bit 7.
- R6: Control bit 1 selects the capture register as the ceiling. With the bit clear, the ceiling is 0xFFFF.
- R7: On a running clock where the counter equals compare A (or B), flag bit 6 (or 5) sets. If control bit 3 (or 4) is set, output A (or B) toggles. Outputs are 0 after reset.
- R8: A rising edge on the selected capture source loads the current counter into the capture register and sets flag bit 3. The source is the capture pin, or the alternate input when control bit 2 is set. Falling edges and edges on the unselected input change nothing.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it. An event in the same cycle wins over the clear.
- R10: The interrupt output is high exactly when the global enable is high and some flag bit is set with its mask bit set. Only mask bits 7, 6, 5 and 3 are writable.
- R11: After reset, control, mask, flags, all wide registers and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (moves the high byte into the latch on low-byte reads) |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| cap_pin | input | 1 | Primary capture input, asynchronous |
| cap_alt | input | 1 | Alternate capture input, asynchronous |
| global_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| cmp_a_out | output | 1 | Compare A toggle output |
| cmp_b_out | output | 1 | Compare B toggle output |

## Verification
The bench builds the block with its defaults: a 16-bit count, four wide registers and a two-stage synchronizer. With the counter stopped, a preload to 0xFFFE makes the fixed-ceiling wrap reachable in a few cycles. With the capture register as ceiling, small random ceilings let long random run lengths pass through many wraps, each predicted by a bench function. The fixed synchronizer depth lets the bench park the counter at a known value and check the exact captured word, including the latch holding a stale high byte across a capture.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int WIDE_W  = 2 * BYTE_W;
  localparam int NWIDE   = 4;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd2;

  // wide register slot numbers (slot n lives at 4+2n / 5+2n)
  localparam int W_CNT  = 0;
  localparam int W_CMPA = 1;
  localparam int W_CMPB = 2;
  localparam int W_CAP  = 3;

  // event bit positions, shared by mask and flag bytes
  localparam int F_OVF  = 7;
  localparam int F_CMPA = 6;
  localparam int F_CMPB = 5;
  localparam int F_CAP  = 3;
  localparam logic [BYTE_W-1:0] EV_BITS = 8'b1110_1000;

  typedef struct packed {
    logic [2:0] spare;
    logic       tog_b;
    logic       tog_a;
    logic       alt_src;
    logic       top_cap;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr_byte_bridge.sv
module tmr_byte_bridge
  import tmr_pkg::*;
#(
  parameter int NREG = NWIDE
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [BYTE_W-1:0]            bus_wdata,
  input  logic [BYTE_W-1:0]            ctrl_byte,
  input  logic [BYTE_W-1:0]            mask_byte,
  input  logic [BYTE_W-1:0]            flag_byte,
  input  logic [NREG-1:0][WIDE_W-1:0]  reg_vals,
  output logic [BYTE_W-1:0]            bus_rdata,
  output logic [NREG-1:0]              wide_we,
  output logic [WIDE_W-1:0]            wide_wval,
  output logic [BYTE_W-1:0]            hold_q
);
  localparam int SLOT_W = ADDR_W - 1;
  localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;

  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  sel;
  logic              is_wide, is_hi;

  assign slot    = bus_addr[ADDR_W-1:1] - SLOT_W'(2);
  assign is_wide = (bus_addr[ADDR_W-1:1] >= SLOT_W'(2)) && (slot < SLOT_W'(NREG));
  assign is_hi   = bus_addr[0];
  assign sel     = slot[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (is_wide && bus_wr && is_hi) begin
      hold_q <= bus_wdata;
    end else if (is_wide && bus_rd && !is_hi) begin
      hold_q <= reg_vals[sel][WIDE_W-1:BYTE_W];
    end
  end

  assign wide_wval = {hold_q, bus_wdata};

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign wide_we[i] = bus_wr && is_wide && !is_hi && (sel == IDX_W'(i));
  end

  always_comb begin
    bus_rdata = '0;
    if (is_wide) begin
      bus_rdata = is_hi ? hold_q : reg_vals[sel][BYTE_W-1:0];
    end else begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_byte;
        A_MASK:  bus_rdata = mask_byte;
        A_FLAG:  bus_rdata = flag_byte;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WIDE_W-1:0] top_val,
  input  logic              ld_en,
  input  logic [WIDE_W-1:0] ld_val,
  output logic [WIDE_W-1:0] cnt_q,
  output logic              wrap_evt
);
  assign wrap_evt = run && !ld_en && (cnt_q == top_val);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (ld_en)    cnt_q <= ld_val;
    else if (wrap_evt) cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + WIDE_W'(1);
  end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WIDE_W-1:0] cnt,
  input  logic              ld_en,
  input  logic [WIDE_W-1:0] ld_val,
  input  logic              tog_en,
  output logic [WIDE_W-1:0] cmp_q,
  output logic              match_evt,
  output logic              wave_q
);
  assign match_evt = run && (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (ld_en) cmp_q <= ld_val;
      if (match_evt && tog_en) wave_q <= !wave_q;
    end
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_pin,
  input  logic              src_alt,
  input  logic              use_alt,
  input  logic [WIDE_W-1:0] cnt,
  input  logic              ld_en,
  input  logic [WIDE_W-1:0] ld_val,
  output logic [WIDE_W-1:0] cap_q,
  output logic              cap_evt
);
  logic [SYNC_STAGES-1:0] sync_pin, sync_alt;
  logic                   level, level_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_pin <= '0;
      sync_alt <= '0;
    end else begin
      sync_pin <= {sync_pin[SYNC_STAGES-2:0], src_pin};
      sync_alt <= {sync_alt[SYNC_STAGES-2:0], src_alt};
    end
  end

  assign level   = use_alt ? sync_alt[SYNC_STAGES-1] : sync_pin[SYNC_STAGES-1];
  assign cap_evt = level && !level_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_d <= 1'b0;
      cap_q   <= '0;
    end else begin
      level_d <= level;
      if (cap_evt)    cap_q <= cnt;
      else if (ld_en) cap_q <= ld_val;
    end
  end
endmodule

// File: rtl/timer16_atomic.sv
module timer16_atomic
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cap_pin,
  input  logic              cap_alt,
  input  logic              global_ie,
  output logic              irq,
  output logic              cmp_a_out,
  output logic              cmp_b_out
);
  ctrl_t                      ctrl_q;
  logic [BYTE_W-1:0]          mask_q, flag_q, flag_set, flag_clr, hold_q;
  logic [NWIDE-1:0][WIDE_W-1:0] wide_vals;
  logic [NWIDE-1:0]           wide_we;
  logic [WIDE_W-1:0]          wide_wval, cnt_q, cap_q, top_val;
  logic                       wrap_evt, cap_evt;
  logic [1:0]                 match_evt, wave, tog_en;
  logic [1:0][WIDE_W-1:0]     cmp_vals;

  tmr_byte_bridge #(.NREG(NWIDE)) u_bridge (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctrl_byte(ctrl_q), .mask_byte(mask_q), .flag_byte(flag_q),
    .reg_vals(wide_vals), .bus_rdata(bus_rdata),
    .wide_we(wide_we), .wide_wval(wide_wval), .hold_q(hold_q)
  );

  assign top_val = ctrl_q.top_cap ? cap_q : '1;

  tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .top_val(top_val),
    .ld_en(wide_we[W_CNT]), .ld_val(wide_wval),
    .cnt_q(cnt_q), .wrap_evt(wrap_evt)
  );

  assign tog_en = {ctrl_q.tog_b, ctrl_q.tog_a};

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    tmr_cmp_chan u_ch (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .cnt(cnt_q),
      .ld_en(wide_we[W_CMPA + c]), .ld_val(wide_wval),
      .tog_en(tog_en[c]), .cmp_q(cmp_vals[c]),
      .match_evt(match_evt[c]), .wave_q(wave[c])
    );
  end

  tmr_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_pin(cap_pin), .src_alt(cap_alt),
    .use_alt(ctrl_q.alt_src), .cnt(cnt_q),
    .ld_en(wide_we[W_CAP]), .ld_val(wide_wval),
    .cap_q(cap_q), .cap_evt(cap_evt)
  );

  assign wide_vals[W_CNT]  = cnt_q;
  assign wide_vals[W_CMPA] = cmp_vals[0];
  assign wide_vals[W_CMPB] = cmp_vals[1];
  assign wide_vals[W_CAP]  = cap_q;

  always_comb begin
    flag_set         = '0;
    flag_set[F_OVF]  = wrap_evt;
    flag_set[F_CMPA] = match_evt[0];
    flag_set[F_CMPB] = match_evt[1];
    flag_set[F_CAP]  = cap_evt;
  end

  assign flag_clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'({3'b000, bus_wdata[4:0]});
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata & EV_BITS;
      flag_q <= ((flag_q & ~flag_clr) | flag_set) & EV_BITS;
    end
  end

  assign irq       = global_ie && ((mask_q & flag_q) != '0);
  assign cmp_a_out = wave[0];
  assign cmp_b_out = wave[1];
endmodule

// File: rtl/timer16_atomic_chk.sv
module timer16_atomic_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              global_ie,
  input logic              irq,
  input logic              cmp_a_out,
  input logic [BYTE_W-1:0] hold_q,
  input logic [WIDE_W-1:0] cnt_q,
  input logic [WIDE_W-1:0] top_val,
  input logic [WIDE_W-1:0] cmpa_q,
  input logic [WIDE_W-1:0] cap_q,
  input logic [BYTE_W-1:0] flag_q,
  input logic [NWIDE-1:0]  wide_we,
  input logic              run,
  input logic              match_a,
  input logic              cap_evt
);
  assert_hold_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0] && bus_addr >= 4'd5 && bus_addr <= 4'd11) |=> hold_q == $past(bus_wdata));

  assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd6) |=> cmpa_q == {$past(hold_q), $past(bus_wdata)});

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wide_we[W_CNT] && cnt_q != top_val) |=> cnt_q == $past(cnt_q) + 16'd1);

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wide_we[W_CNT]) |=> $stable(cnt_q));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wide_we[W_CNT] && cnt_q == top_val) |=> (cnt_q == '0) && flag_q[F_OVF]);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_a_out) |-> $past(match_a));

  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !wide_we[W_CAP]) |=> $stable(cap_q));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FLAG && bus_wdata[F_CAP] && !cap_evt) |=> !flag_q[F_CAP]);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (global_ie && flag_q != '0));
endmodule

bind timer16_atomic timer16_atomic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .global_ie(global_ie), .irq(irq),
  .cmp_a_out(cmp_a_out), .hold_q(hold_q), .cnt_q(cnt_q), .top_val(top_val),
  .cmpa_q(cmp_vals[0]), .cap_q(cap_q), .flag_q(flag_q), .wide_we(wide_we),
  .run(ctrl_q.run), .match_a(match_evt[0]), .cap_evt(cap_evt)
);

// File: tb/sim_timer16_atomic.sv
module sim_timer16_atomic;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       cap_pin = 1'b0, cap_alt = 1'b0, global_ie = 1'b0;
  logic       irq, cmp_a_out, cmp_b_out;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = !clk;

  timer16_atomic u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cap_alt(cap_alt), .global_ie(global_ie),
    .irq(irq), .cmp_a_out(cmp_a_out), .cmp_b_out(cmp_b_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic w16(input int slot, input logic [15:0] v);
    bw(4'(4 + 2 * slot + 1), v[15:8]);
    bw(4'(4 + 2 * slot), v[7:0]);
  endtask

  task automatic r16(input int slot, output logic [15:0] v);
    logic [7:0] lo, hi;
    br(4'(4 + 2 * slot), lo);
    br(4'(4 + 2 * slot + 1), hi);
    v = {hi, lo};
  endtask

  // counter after n steps from start, wrapping past top; returns wrap count via ref
  function automatic logic [15:0] exp_count(input logic [15:0] start, input logic [15:0] top,
                                            input int n, output int wraps);
    logic [15:0] c = start;
    wraps = 0;
    for (int i = 0; i < n; i++) begin
      if (c == top) begin c = '0; wraps++; end
      else c = c + 16'd1;
    end
    return c;
  endfunction

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, e;
    int          wr, m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    br(4'd1, b); chk("R11 mask", 16'(b), 16'h0);
    br(4'd2, b); chk("R11 flags", 16'(b), 16'h0);
    br(4'd0, b); chk("R11 ctrl", 16'(b), 16'h0);
    r16(3, v);  chk("R11 capture", v, 16'h0);
    chk("R11 outputs", {14'd0, cmp_a_out, cmp_b_out}, 16'h0);
    chk("R10 irq after reset", 16'(irq), 16'h0);

    // R1 high write alone leaves the register untouched
    bw(4'd7, 8'hAB);
    r16(1, v); chk("R1 compare A after high-only write", v, 16'h0000);

    // R4 shared latch: later high write to B supplies the byte committed to A
    bw(4'd7, 8'h11); bw(4'd9, 8'h22); bw(4'd6, 8'h33);
    r16(1, v); chk("R4 shared latch", v, 16'h2233);

    // R2 random full writes and readbacks (counter stopped)
    for (int i = 0; i < 16; i++) begin
      int s = int'($urandom_range(3, 0));
      e = 16'($urandom);
      w16(s, e);
      r16(s, v); chk("R2 wide write/readback", v, e);
    end

    // R6 fixed ceiling: wrap at 0xFFFF
    bw(4'd2, 8'hFF);
    w16(0, 16'hFFFE);
    bw(4'd0, 8'h01); @(negedge clk); bw(4'd0, 8'h00);
    r16(0, v); chk("R6 fixed ceiling wrap", v, 16'h0001);
    br(4'd2, b); chk("R5 overflow flag", 16'(b[7]), 16'h1);

    // R5 / R6 random runs with capture register as ceiling
    for (int i = 0; i < 10; i++) begin
      logic [15:0] top, st;
      top = 16'($urandom_range(200, 16));
      st  = 16'($urandom_range(int'(top), 0));
      m   = int'($urandom_range(300, 0));
      bw(4'd2, 8'hFF);
      w16(3, top); w16(0, st);
      bw(4'd0, 8'h03);
      repeat (m) @(negedge clk);
      bw(4'd0, 8'h00);
      e = exp_count(st, top, m + 2, wr);
      r16(0, v); chk("R5 count with capture ceiling", v, e);
      br(4'd2, b); chk("R6 overflow after ceiling wrap", 16'(b[7]), 16'(wr > 0));
    end

    // R5 held while stopped
    w16(0, 16'h0042); repeat (20) @(negedge clk);
    r16(0, v); chk("R5 hold while stopped", v, 16'h0042);

    // R7 compare: two steps reach 5 but no match yet, third step matches
    bw(4'd2, 8'hFF);
    w16(1, 16'd5); w16(2, 16'd9); w16(0, 16'd3);
    bw(4'd0, 8'h09); bw(4'd0, 8'h00);
    br(4'd2, b); chk("R7 no match before count equals", 16'(b[6]), 16'h0);
    chk("R7 output A before match", 16'(cmp_a_out), 16'h0);
    w16(0, 16'd3);
    bw(4'd0, 8'h19); @(negedge clk); bw(4'd0, 8'h00);
    br(4'd2, b); chk("R7 compare A flag", 16'(b[6]), 16'h1);
    chk("R7 compare B flag clear", 16'(b[5]), 16'h0);
    chk("R7 outputs A toggled B not", {14'd0, cmp_a_out, cmp_b_out}, 16'h2);

    // R8 capture from pin
    bw(4'd2, 8'hFF);
    w16(0, 16'h1234);
    @(negedge clk); cap_pin = 1'b1; repeat (5) @(negedge clk);
    r16(3, v); chk("R8 capture on pin rise", v, 16'h1234);
    br(4'd2, b); chk("R8 capture flag", 16'(b[3]), 16'h1);
    bw(4'd2, 8'h08);
    w16(0, 16'h2222);
    @(negedge clk); cap_pin = 1'b0; repeat (5) @(negedge clk);
    @(negedge clk); cap_alt = 1'b1; repeat (5) @(negedge clk);
    @(negedge clk); cap_alt = 1'b0; repeat (5) @(negedge clk);
    r16(3, v); chk("R8 falling and unselected edges ignored", v, 16'h1234);
    br(4'd2, b); chk("R8 no flag on ignored edges", 16'(b[3]), 16'h0);

    // R8 alternate source
    bw(4'd0, 8'h04);
    @(negedge clk); cap_alt = 1'b1; repeat (5) @(negedge clk);
    r16(3, v); chk("R8 capture from alternate input", v, 16'h2222);

    // R3 latch keeps the high byte from the low read across a new capture
    @(negedge clk); cap_alt = 1'b0; repeat (5) @(negedge clk);
    w16(0, 16'h5566); w16(3, 16'h0ABC);
    br(4'd10, b); chk("R3 low byte", 16'(b), 16'h00BC);
    @(negedge clk); cap_alt = 1'b1; repeat (5) @(negedge clk);
    br(4'd11, b); chk("R3 high byte from latch", 16'(b), 16'h000A);
    r16(3, v); chk("R3 fresh pair read", v, 16'h5566);

    // R9 write-one-to-clear touches only selected bits
    bw(4'd2, 8'hFF); w16(1, 16'd0); w16(2, 16'd0);
    w16(0, 16'hFFFE); bw(4'd0, 8'h05); @(negedge clk); bw(4'd0, 8'h04);
    @(negedge clk); cap_alt = 1'b0; repeat (4) @(negedge clk);
    @(negedge clk); cap_alt = 1'b1; repeat (5) @(negedge clk);
    br(4'd2, b); chk("R9 overflow and capture set", 16'(b & 8'h88), 16'h0088);
    bw(4'd2, 8'h08);
    br(4'd2, b); chk("R9 clear capture only", 16'(b & 8'h88), 16'h0080);

    // R10 interrupt gating
    bw(4'd1, 8'hFF);
    br(4'd1, b); chk("R10 writable mask bits", 16'(b), 16'h00E8);
    bw(4'd1, 8'h08);
    global_ie = 1'b1; #1;
    chk("R10 masked-off flag gives no irq", 16'(irq), 16'h0);
    bw(4'd1, 8'h80); #1;
    chk("R10 irq asserted", 16'(irq), 16'h1);
    global_ie = 1'b0; #1;
    chk("R10 global enable off", 16'(irq), 16'h0);
    global_ie = 1'b1;
    bw(4'd2, 8'h80); #1;
    chk("R10 irq drops after clear", 16'(irq), 16'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule